// File: doc/BRIEF.md
# Migration Decision Predictor

This block sits beside a core's memory stage and answers one question for every data access whose home core is not the core the thread is running on: should the thread move to that core, or should the core send a single-word request there and wait for the reply? The answer comes from a direct-mapped table indexed by the program counter. A valid entry whose stored PC equals the requesting PC means "move". Any other outcome means "stay and access remotely". When the answer is "move", the block also returns the set of general registers that were useful the last time this instruction started a run of accesses to one remote core. The outgoing context is built from that set.

The table is filled from two sides. A sequence detector, outside this block, finds instructions that start long runs of accesses to one home core. It writes the start PC and the registers used during the run into the table. When a thread that left with too few registers touches a register it did not carry, it comes back and reports the PC and the missing register. The block then adds that register to the stored set. A set never loses a member except when the entry is rewritten by a new insert.

All three request ports are valid-qualified and have no ready signal. The block takes one request on each port in every cycle, so it never applies back-pressure. The lookup answer appears as a one-cycle valid pulse in the cycle after the request and must be consumed then.

Top module: `mig_predictor`

## Requirements
- R1: For each cycle with `lk_valid` high, `rs_valid` is high in the following cycle. In every other cycle it is low.
- R2: A lookup flagged as a core miss whose PC hits gives `rs_migrate`=1 and `rs_mask` equal to the stored register set in the next cycle. A hit needs a valid entry at the PC's index whose stored PC equals all PC_W bits of the request.
- R3: A core-miss lookup that does not hit gives `rs_migrate`=0 (remote access) and `rs_mask`=0.
- R4: A lookup with `lk_core_miss`=0 gives `rs_migrate`=0 and `rs_mask`=0, whatever the table holds.
- R5: The table index is PC bits [log2(DEPTH):1], so bit 0 takes no part in it. PCs that share an index but differ in any other bit, bit 0 included, do not hit each other's entry.
- R6: An insert writes its PC and mask into the entry at the PC's index and marks the entry valid. Any earlier occupant of that index is replaced.
- R7: A learn whose PC matches a valid entry sets bit `ln_reg` of that entry's mask and keeps all other bits. A learn whose PC matches no valid entry changes nothing.
- R8: When an insert and a learn target the same index in the same cycle, only the insert takes effect.
- R9: A lookup in the same cycle as an insert or learn to its index returns the entry's contents from before that write.
- R10: Reset clears every valid bit, so every lookup after reset is a remote access until an insert is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | PC_W | PC of the memory instruction |
| lk_core_miss | input | 1 | High when the home core differs from the current core |
| ins_valid | input | 1 | Insert request present |
| ins_pc | input | PC_W | Start PC of a detected run |
| ins_mask | input | NREG | Registers used during the run |
| ln_valid | input | 1 | Register-miss report present |
| ln_pc | input | PC_W | PC whose entry learns |
| ln_reg | input | log2(NREG) | Index of the register that was missing |
| rs_valid | output | 1 | Lookup answer present, one cycle after the request |
| rs_migrate | output | 1 | 1 = migrate, 0 = remote access |
| rs_mask | output | NREG | Registers to carry when migrating, zero otherwise |

## Verification
The assertions assume that `ln_reg` is below NREG. They also assume that every request port is sampled only through its valid bit, with payloads allowed to change freely. The stimulus draws register numbers only from that range and drives payloads even when their valid bit is low. The random stimulus draws PCs from a small pool in which several PCs share each index and one pair differs only in bit 0. Because of this, aliasing, overwriting, learns on absent PCs, and same-cycle collisions between inserts, learns and lookups all occur often, alongside directed cases for reset, register 31 and a collision between an insert and a learn.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_INSERT = 2'd1,
    WR_LEARN  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/mp_index.sv
module mp_index #(
  parameter int PC_W  = 64,
  parameter int IDX_W = 7
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [PC_W-1:0]  tag_o
);
  // bit 0 is skipped; the full PC is kept as the tag
  assign idx_o = pc_i[IDX_W:1];
  assign tag_o = pc_i;
endmodule

// File: rtl/mp_entry.sv
module mp_entry
  import mp_pkg::*;
#(
  parameter int PC_W   = 64,
  parameter int NREG   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_we_i,
  input  logic [PC_W-1:0]   ins_pc_i,
  input  logic [NREG-1:0]   ins_mask_i,
  input  logic              ln_req_i,
  input  logic [PC_W-1:0]   ln_pc_i,
  input  logic [RIDX_W-1:0] ln_reg_i,
  output logic              v_o,
  output logic [PC_W-1:0]   tag_o,
  output logic [NREG-1:0]   mask_o
);
  logic            v_q;
  logic [PC_W-1:0] tag_q;
  logic [NREG-1:0] mask_q;
  logic [NREG-1:0] ln_bit;
  wr_kind_e        kind;

  assign ln_bit = {{(NREG-1){1'b0}}, 1'b1} << ln_reg_i;

  always_comb begin
    if (ins_we_i)                                   kind = WR_INSERT;
    else if (ln_req_i && v_q && (tag_q == ln_pc_i)) kind = WR_LEARN;
    else                                            kind = WR_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 v_q <= 1'b0;
    else if (kind == WR_INSERT) v_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    case (kind)
      WR_INSERT: begin
        tag_q  <= ins_pc_i;
        mask_q <= ins_mask_i;
      end
      WR_LEARN: mask_q <= mask_q | ln_bit;
      default: ;
    endcase
  end

  assign v_o    = v_q;
  assign tag_o  = tag_q;
  assign mask_o = mask_q;

  AST_INSERT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_we_i |=> (v_q && tag_q == $past(ins_pc_i) && mask_q == $past(ins_mask_i))); // R6

  AST_MASK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WR_LEARN) |=> (((mask_q & $past(mask_q)) == $past(mask_q)) && mask_q[$past(ln_reg_i)])); // R7

  AST_LEARN_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_we_i && ln_req_i) |=> (mask_q == $past(ins_mask_i))); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_we_i && !ln_req_i) |=> ($stable(mask_q) && $stable(v_q))); // R7
endmodule

// File: rtl/mp_lookup.sv
module mp_lookup #(
  parameter int PC_W = 64,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid_i,
  input  logic [PC_W-1:0] lk_tag_i,
  input  logic            lk_core_miss_i,
  input  logic            rd_v_i,
  input  logic [PC_W-1:0] rd_tag_i,
  input  logic [NREG-1:0] rd_mask_i,
  output logic            rs_valid_o,
  output logic            rs_migrate_o,
  output logic [NREG-1:0] rs_mask_o
);
  logic pc_hit;
  logic go;

  assign pc_hit = rd_v_i && (rd_tag_i == lk_tag_i);
  assign go     = lk_valid_i && lk_core_miss_i && pc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid_o   <= 1'b0;
      rs_migrate_o <= 1'b0;
      rs_mask_o    <= '0;
    end else begin
      rs_valid_o   <= lk_valid_i;
      rs_migrate_o <= go;
      rs_mask_o    <= go ? rd_mask_i : '0;
    end
  end

  AST_ANSWER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |=> rs_valid_o); // R1

  AST_NO_STRAY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |=> !rs_valid_o); // R1

  AST_LOCAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && !lk_core_miss_i) |=> (!rs_migrate_o && rs_mask_o == '0)); // R4

  AST_REMOTE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_migrate_o |-> (rs_mask_o == '0)); // R3
endmodule

// File: rtl/mig_predictor.sv
module mig_predictor #(
  parameter int PC_W   = 64,
  parameter int NREG   = 32,
  parameter int DEPTH  = 128,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic              lk_core_miss,
  input  logic              ins_valid,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic [NREG-1:0]   ins_mask,
  input  logic              ln_valid,
  input  logic [PC_W-1:0]   ln_pc,
  input  logic [RIDX_W-1:0] ln_reg,
  output logic              rs_valid,
  output logic              rs_migrate,
  output logic [NREG-1:0]   rs_mask
);
  logic [IDX_W-1:0] lk_idx, ins_idx, ln_idx;
  logic [PC_W-1:0]  lk_tag, ins_tag, ln_tag;

  logic            ent_v    [DEPTH];
  logic [PC_W-1:0] ent_tag  [DEPTH];
  logic [NREG-1:0] ent_mask [DEPTH];
  logic [DEPTH-1:0] ins_sel, ln_sel;

  mp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_ix_lk (
    .pc_i(lk_pc), .idx_o(lk_idx), .tag_o(lk_tag));
  mp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_ix_ins (
    .pc_i(ins_pc), .idx_o(ins_idx), .tag_o(ins_tag));
  mp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_ix_ln (
    .pc_i(ln_pc), .idx_o(ln_idx), .tag_o(ln_tag));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign ins_sel[g] = ins_valid && (ins_idx == IDX_W'(g));
    assign ln_sel[g]  = ln_valid  && (ln_idx  == IDX_W'(g));
    mp_entry #(.PC_W(PC_W), .NREG(NREG), .RIDX_W(RIDX_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_we_i   (ins_sel[g]),
      .ins_pc_i   (ins_tag),
      .ins_mask_i (ins_mask),
      .ln_req_i   (ln_sel[g]),
      .ln_pc_i    (ln_tag),
      .ln_reg_i   (ln_reg),
      .v_o        (ent_v[g]),
      .tag_o      (ent_tag[g]),
      .mask_o     (ent_mask[g])
    );
  end

  mp_lookup #(.PC_W(PC_W), .NREG(NREG)) u_lookup (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid_i     (lk_valid),
    .lk_tag_i       (lk_tag),
    .lk_core_miss_i (lk_core_miss),
    .rd_v_i         (ent_v[lk_idx]),
    .rd_tag_i       (ent_tag[lk_idx]),
    .rd_mask_i      (ent_mask[lk_idx]),
    .rs_valid_o     (rs_valid),
    .rs_migrate_o   (rs_migrate),
    .rs_mask_o      (rs_mask)
  );

  AST_ONE_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ins_sel) && $onehot0(ln_sel)); // R6

  AST_FRESH_ENTRY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && lk_valid && lk_core_miss && !(ins_valid && ins_pc != lk_pc)) ##1
    (lk_valid && lk_core_miss && lk_pc == $past(lk_pc) && !ins_valid) |=> rs_migrate); // R2

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rs_migrate); // R10
endmodule

// File: tb/sim_mig_predictor.sv
module sim_mig_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 64;
  localparam int NREG  = 32;
  localparam int DEPTH = 128;
  localparam int IDX_W = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            lk_valid = 1'b0, lk_core_miss = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            ins_valid = 1'b0;
  logic [PC_W-1:0] ins_pc = '0;
  logic [NREG-1:0] ins_mask = '0;
  logic            ln_valid = 1'b0;
  logic [PC_W-1:0] ln_pc = '0;
  logic [4:0]      ln_reg = '0;
  logic            rs_valid, rs_migrate;
  logic [NREG-1:0] rs_mask;

  int n_chk = 0;
  int n_bad = 0;

  logic            m_v    [DEPTH];
  logic [PC_W-1:0] m_tag  [DEPTH];
  logic [NREG-1:0] m_mask [DEPTH];
  logic [PC_W-1:0] pool [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  mig_predictor #(.PC_W(PC_W), .NREG(NREG), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_core_miss(lk_core_miss),
    .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_mask(ins_mask),
    .ln_valid(ln_valid), .ln_pc(ln_pc), .ln_reg(ln_reg),
    .rs_valid(rs_valid), .rs_migrate(rs_migrate), .rs_mask(rs_mask));

  function automatic logic [IDX_W-1:0] ix(input logic [PC_W-1:0] pc);
    return pc[IDX_W:1];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
  endtask

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic step(input logic lv, input logic [PC_W-1:0] lpc, input logic lcm,
                      input logic iv, input logic [PC_W-1:0] ipc, input logic [NREG-1:0] imsk,
                      input logic nv, input logic [PC_W-1:0] npc, input logic [4:0] nreg,
                      input string req);
    logic hit, e_mig;
    logic [NREG-1:0] e_mask;
    string tag;
    lk_valid = lv; lk_pc = lpc; lk_core_miss = lcm;
    ins_valid = iv; ins_pc = ipc; ins_mask = imsk;
    ln_valid = nv; ln_pc = npc; ln_reg = nreg;
    hit    = m_v[ix(lpc)] && (m_tag[ix(lpc)] == lpc);
    e_mig  = lv && lcm && hit;
    e_mask = e_mig ? m_mask[ix(lpc)] : '0;
    if (req != "") tag = req;
    else if (!lv)  tag = "R1";
    else if (!lcm) tag = "R4";
    else if (hit)  tag = "R2";
    else           tag = "R3";
    // R8: insert wins over learn on the same index
    if (nv && m_v[ix(npc)] && m_tag[ix(npc)] == npc && !(iv && ix(ipc) == ix(npc)))
      m_mask[ix(npc)] = m_mask[ix(npc)] | (NREG'(1) << nreg);
    if (iv) begin
      m_v[ix(ipc)] = 1'b1; m_tag[ix(ipc)] = ipc; m_mask[ix(ipc)] = imsk;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rs_valid",   64'(rs_valid),   64'(lv));
    chk(tag, "rs_migrate", 64'(rs_migrate), 64'(e_mig));
    chk(tag, "rs_mask",    64'(rs_mask),    64'(e_mask));
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input logic cm, input string req);
    step(1'b1, pc, cm, 1'b0, '0, '0, 1'b0, '0, 5'd0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] a, b;
    void'($urandom(32'd20251));
    model_clear();
    a = 64'h0000_7F00_1234_0040;
    b = a | (64'd1 << 40);              // same index as a, other tag
    for (int i = 0; i < 8; i++) begin
      pool[i] = {$urandom(), $urandom()};
      pool[i][7:0] = {7'(i % 4), 1'b0};
    end
    pool[7] = pool[3] | 64'd1;          // differs from pool[3] only in bit 0

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "rs_valid after reset", 64'(rs_valid), 64'd0);

    look(a, 1'b1, "R10");
    // R9: lookup during the insert sees the empty slot
    step(1'b1, a, 1'b1, 1'b1, a, 32'h5, 1'b0, '0, 5'd0, "R9");
    look(a, 1'b1, "R6");
    look(a, 1'b0, "R4");
    look(a | 64'd1, 1'b1, "R5");
    look(a + 64'd2, 1'b1, "R5");
    look(b, 1'b1, "R5");
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, a, 5'd31, "R1");
    look(a, 1'b1, "R7");                // mask 8000_0005
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, b, 5'd3, "R7");
    look(a, 1'b1, "R7");
    look(b, 1'b1, "R7");
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, a, 5'd0, "R7");
    look(a, 1'b1, "R7");
    // R9: lookup during a learn sees the old mask
    step(1'b1, a, 1'b1, 1'b0, '0, '0, 1'b1, a, 5'd8, "R9");
    look(a, 1'b1, "R7");
    // R8: insert and learn on the same entry
    step(1'b0, '0, 1'b0, 1'b1, a, 32'h10, 1'b1, a, 5'd2, "R8");
    look(a, 1'b1, "R8");
    step(1'b0, '0, 1'b0, 1'b1, b, 32'h2, 1'b1, a, 5'd9, "R8");
    look(b, 1'b1, "R6");
    look(a, 1'b1, "R6");

    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 3) != 0, pool[$urandom_range(0, 7)], $urandom_range(0, 3) != 0,
           $urandom_range(0, 5) == 0, pool[$urandom_range(0, 7)], $urandom(),
           $urandom_range(0, 3) == 0, pool[$urandom_range(0, 7)], 5'($urandom_range(0, 31)),
           "");
    end

    // R10: reset in the middle of a run
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) look(pool[i], 1'b1, "R10");
    look(b, 1'b1, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule